// File: doc/BRIEF.md
# Retriggerable Mute One-Shot

This block drives a radio's mute line for a fixed number of ticks of a slow time base after each station change. The controller loads a new setting through a serial port, which is outside this block. On each load strobe the block looks at the latched arm bit and the two output-mode bits. When the output mode is normal and the arm bit is high, a pulse starts at once. For the length of the pulse the pin shows the inverse of the normal status bit. When no pulse is running, the pin shows the status bit unchanged.

The time base is a one-cycle tick at 50 Hz, made elsewhere from the crystal divider chain. Fifteen ticks give a pulse of about 300 ms. A second arming strobe during a pulse reloads the full count, so the pulse gets longer. A strobe with the arm bit low leaves a running pulse alone. After reset the block spends one full pulse length settling, and it ignores arming strobes until that has passed. All state is synchronous to one clock and uses an active-high synchronous reset.

Top module: `mute_oneshot`

## Requirements
- R1: While reset is high the pin is 0. On the first clock after reset goes low the pin follows the status bit.
- R2: For the first PULSE_TICKS ticks after reset (settling), strobes are ignored and the pin equals the status bit.
- R3: After settling, a strobe with arm=1 and mode bits 2'b00 (normal) inverts the pin from the clock edge that samples the strobe.
- R4: A strobe with arm=1 and mode bits 2'b01, 2'b10 or 2'b11 starts no pulse.
- R5: arm=1 without a strobe starts no pulse.
- R6: A pulse ends at the clock edge that samples the PULSE_TICKS-th tick after its trigger. A tick in the trigger cycle is not counted.
- R7: A strobe with arm=0 during a pulse neither ends nor shortens it.
- R8: An arming strobe during a pulse reloads the count to PULSE_TICKS.
- R9: With no pulse running, the pin equals the status bit, registered one clock.
- R10: While the mode bits are not 2'b00, the pin equals the status bit. A running pulse keeps counting and shows again once the mode returns to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| load_stb_i | input | 1 | One-cycle strobe when new serial data is latched |
| arm_i | input | 1 | Latched arm bit (starts or extends a pulse) |
| outmode_i | input | 2 | Latched output-mode bits; 2'b00 is normal |
| status_i | input | 1 | Latched normal status bit for the pin |
| tick50_i | input | 1 | One-cycle 50 Hz time-base tick |
| mute_pin_o | output | 1 | Registered pin: status, inverted during a pulse |

## Verification
A pulse counter holding a wrong value shows up at the pin as a pulse that ends one or more ticks early or late. The bench therefore checks the pin after every tick of each pulse, and the first wrong tick shows as a single miscompare. A settling flag stuck low lets a strobe during the first PULSE_TICKS ticks invert the pin on the next clock. A stuck-high flag means no trigger ever takes effect. An error in the mode gate or the output multiplexer shows one clock after the mode or status input changes.

// File: rtl/mute_pkg.sv
package mute_pkg;
  typedef enum logic [1:0] {
    OMODE_NORMAL = 2'b00,
    OMODE_TEST1  = 2'b01,
    OMODE_TEST2  = 2'b10,
    OMODE_TEST3  = 2'b11
  } outmode_e;

  function automatic logic is_normal(input logic [1:0] m);
    return m == OMODE_NORMAL;
  endfunction
endpackage

// File: rtl/mute_settle_guard.sv
module mute_settle_guard #(
  parameter int SETTLE_TICKS = 15,
  localparam int W = $clog2(SETTLE_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  output logic settling_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= W'(SETTLE_TICKS);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign settling_o = cnt_q != '0;
endmodule

// File: rtl/mute_trigger.sv
module mute_trigger (
  input  logic       strobe_i,
  input  logic       arm_i,
  input  logic [1:0] mode_i,
  input  logic       settling_i,
  output logic       fire_o
);
  import mute_pkg::*;
  assign fire_o = strobe_i && arm_i && is_normal(mode_i) && !settling_i;
endmodule

// File: rtl/mute_pulse_counter.sv
module mute_pulse_counter #(
  parameter int PULSE_TICKS = 15,
  localparam int W = $clog2(PULSE_TICKS + 1)
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         active_nxt_o
);
  logic [W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load_i) cnt_nxt = W'(PULSE_TICKS);
    else if (tick_i && cnt_q != '0) cnt_nxt = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nxt;
  end

  assign cnt_o        = cnt_q;
  assign active_nxt_o = cnt_nxt != '0;
endmodule

// File: rtl/mute_pin_reg.sv
module mute_pin_reg (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       active_nxt_i,
  input  logic [1:0] mode_i,
  input  logic       status_i,
  output logic       pin_o
);
  import mute_pkg::*;
  logic pin_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) pin_q <= 1'b0;
    else       pin_q <= (active_nxt_i && is_normal(mode_i)) ? !status_i : status_i;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/mute_oneshot.sv
module mute_oneshot #(
  parameter int PULSE_TICKS = 15,
  localparam int PCNT_W = $clog2(PULSE_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       load_stb_i,
  input  logic       arm_i,
  input  logic [1:0] outmode_i,
  input  logic       status_i,
  input  logic       tick50_i,
  output logic       mute_pin_o
);
  logic              settle_busy;
  logic              fire;
  logic [PCNT_W-1:0] pulse_cnt;
  logic              pulse_nxt;

  mute_settle_guard #(.SETTLE_TICKS(PULSE_TICKS)) u_settle (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick50_i), .settling_o(settle_busy)
  );

  mute_trigger u_trig (
    .strobe_i(load_stb_i), .arm_i(arm_i), .mode_i(outmode_i),
    .settling_i(settle_busy), .fire_o(fire)
  );

  mute_pulse_counter #(.PULSE_TICKS(PULSE_TICKS)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(fire), .tick_i(tick50_i),
    .cnt_o(pulse_cnt), .active_nxt_o(pulse_nxt)
  );

  mute_pin_reg u_pin (
    .clk_i(clk_i), .rst_i(rst_i), .active_nxt_i(pulse_nxt),
    .mode_i(outmode_i), .status_i(status_i), .pin_o(mute_pin_o)
  );
endmodule

// File: rtl/mute_oneshot_chk.sv
module mute_oneshot_chk #(
  parameter int PULSE_TICKS = 15,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             load_stb_i,
  input logic             arm_i,
  input logic [1:0]       outmode_i,
  input logic             status_i,
  input logic             tick50_i,
  input logic             mute_pin_o,
  input logic             settling_i,
  input logic [CNT_W-1:0] pulse_cnt_i
);
  // R2: strobes during settling leave the pin at status
  p_settle_ignore_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (settling_i && load_stb_i && arm_i && outmode_i == 2'b00) |=> (mute_pin_o == $past(status_i)));

  // R3: valid arming inverts the pin at once
  p_trigger_invert_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!settling_i && load_stb_i && arm_i && outmode_i == 2'b00) |=> (mute_pin_o == !$past(status_i)));

  // R4 / R10: non-normal mode shows plain status
  p_mode_gate_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (outmode_i != 2'b00) |=> (mute_pin_o == $past(status_i)));

  // R5 / R9: idle without strobe follows status
  p_idle_follow_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (pulse_cnt_i == '0 && !load_stb_i) |=> (mute_pin_o == $past(status_i)));

  // R6: last tick ends the pulse
  p_last_tick_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (pulse_cnt_i == CNT_W'(1) && tick50_i && !load_stb_i) |=> (pulse_cnt_i == '0));

  // R7: disarming strobe does not cancel
  p_no_cancel_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (pulse_cnt_i > CNT_W'(1) && load_stb_i && !arm_i) |=> (pulse_cnt_i != '0));

  // R8: arming reloads the full count
  p_reload_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!settling_i && load_stb_i && arm_i && outmode_i == 2'b00) |=> (pulse_cnt_i == CNT_W'(PULSE_TICKS)));
endmodule

bind mute_oneshot mute_oneshot_chk #(.PULSE_TICKS(PULSE_TICKS), .CNT_W(PCNT_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .load_stb_i(load_stb_i), .arm_i(arm_i),
  .outmode_i(outmode_i), .status_i(status_i), .tick50_i(tick50_i),
  .mute_pin_o(mute_pin_o), .settling_i(settle_busy), .pulse_cnt_i(pulse_cnt)
);

// File: tb/mute_oneshot_bench.sv
module mute_oneshot_bench;
  localparam int P = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0, arm = 1'b0, st = 1'b0, tk = 1'b0;
  logic [1:0] mode = 2'b00;
  logic pin;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mute_oneshot #(.PULSE_TICKS(P)) u_mute_oneshot (
    .clk_i(clk), .rst_i(rst), .load_stb_i(stb), .arm_i(arm), .outmode_i(mode),
    .status_i(st), .tick50_i(tk), .mute_pin_o(pin)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pin=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tick();
    tk = 1'b1; cyc(); tk = 1'b0;
  endtask

  task automatic latch(input logic a, input logic [1:0] m);
    stb = 1'b1; arm = a; mode = m; cyc(); stb = 1'b0; mode = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: pin=%b expected=finished", pin);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); st = 1'b1;
    cyc(); cyc();
    chk("R1 reset", pin, 1'b0);
    rst = 1'b0; cyc();
    chk("R1 after reset", pin, 1'b1);

    // settling: strobes ignored for P ticks
    for (int k = 1; k <= P; k++) begin
      latch(1'b1, 2'b00);
      chk("R2 settle ignore", pin, st);
      tick();
    end
    cyc();

    // R5: arm without strobe
    arm = 1'b1; cyc(); cyc();
    chk("R5 no strobe", pin, 1'b1);
    arm = 1'b0;

    // R4: non-normal modes never trigger
    for (int m = 1; m < 4; m++) begin
      latch(1'b1, 2'(m));
      chk("R4 mode gate", pin, st);
      tick(); tick();
      chk("R4 no pulse", pin, st);
    end

    // R3 / R6: basic pulse length, both status values
    for (int s = 0; s < 2; s++) begin
      st = 1'(s);
      cyc();
      chk("R9 idle", pin, st);
      latch(1'b1, 2'b00);
      chk("R3 invert", pin, !st);
      for (int k = 1; k <= P; k++) begin
        tick();
        chk("R6 length", pin, (k < P) ? !st : st);
      end
    end

    // R9: status change while idle, registered
    st = 1'b1; cyc(); chk("R9 follow high", pin, 1'b1);
    st = 1'b0; cyc(); chk("R9 follow low", pin, 1'b0);
    st = 1'b1; cyc();

    // R7: disarm does not cancel
    latch(1'b1, 2'b00);
    for (int k = 1; k <= 5; k++) tick();
    latch(1'b0, 2'b00);
    chk("R7 disarm keeps", pin, 1'b0);
    for (int k = 6; k <= P; k++) begin
      tick();
      chk("R7 runs out", pin, (k < P) ? 1'b0 : 1'b1);
    end

    // R8: retrigger reloads
    latch(1'b1, 2'b00);
    for (int k = 1; k <= 10; k++) tick();
    latch(1'b1, 2'b00);
    for (int k = 1; k <= P; k++) begin
      tick();
      chk("R8 extended", pin, (k < P) ? 1'b0 : 1'b1);
    end

    // R6: tick coincident with trigger not counted
    tk = 1'b1; latch(1'b1, 2'b00); tk = 1'b0;
    for (int k = 1; k <= P; k++) begin
      tick();
      chk("R6 coincident tick", pin, (k < P) ? 1'b0 : 1'b1);
    end

    // R10: mode leaves normal during pulse
    latch(1'b1, 2'b00);
    for (int k = 1; k <= 3; k++) tick();
    mode = 2'b10; cyc();
    chk("R10 status shown", pin, 1'b1);
    tick(); tick();
    chk("R10 still status", pin, 1'b1);
    mode = 2'b00; cyc();
    chk("R10 pulse back", pin, 1'b0);
    for (int k = 6; k <= P; k++) begin
      tick();
      chk("R10 count kept", pin, (k < P) ? 1'b0 : 1'b1);
    end

    // R1: reset mid-pulse restarts settling
    latch(1'b1, 2'b00);
    rst = 1'b1; cyc();
    chk("R1 reset mid", pin, 1'b0);
    rst = 1'b0; cyc();
    chk("R1 cleared", pin, 1'b1);
    latch(1'b1, 2'b00);
    chk("R2 settle again", pin, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule